// File: doc/BRIEF.md
# Condition Code Flag Update Unit

This unit keeps an 8-bit condition code byte and refreshes its negative, zero, overflow and carry flags after an arithmetic or logic step. The surrounding datapath supplies the two operands, the result it produced, an operation class and a width select, then pulses the update strobe. The unit takes the most significant bit of each value at the selected width and applies fixed carry and overflow equations. It writes the new flags into the register on the next clock edge.

The same byte can also be loaded whole, or one or more of its bits can be forced to 0 or 1 through a mask. Four bits are plain storage and no flag update touches them: sign-extension control (bit 7), extra mask (bit 6), half carry (bit 5) and interrupt mask (bit 4). The flag bits are N (bit 3), Z (bit 2), V (bit 1) and C (bit 0).

Top module: `ccr_flag_unit`

## Requirements
- R1: A synchronous, active-high reset sets the register to 0xD0. After a clock edge with reset high, the output reads 0xD0.
- R2: A full-byte load writes load_val into the register on the next edge. When load_en is high, it takes priority over a flag update and over a bit write in the same cycle.
- R3: For the add class (opc 0), C becomes bit MSB of (a&b)|(b&~r)|(a&~r) and V becomes bit MSB of (a&b&~r)|(~a&~b&r). For a true sum, C is the carry out and V is signed overflow.
- R4: For the subtract class (opc 1), C becomes bit MSB of (~a&b)|(b&r)|(~a&r) and V becomes bit MSB of (a&~b&~r)|(~a&b&r). For a true difference, C is the borrow and V is signed overflow.
- R5: For every class, N takes the result MSB, and Z is set exactly when the result is zero at the selected width.
- R6: The test class (opc 2) clears V and leaves C unchanged.
- R7: The shift class (opc 3) sets V to the XOR of the newly computed N and the C already held, and leaves C unchanged.
- R8: With wide=0, the MSB is bit 7 and operand and result bits 15..8 have no effect. With wide=1, the MSB is bit 15.
- R9: A flag update leaves bits 7..4 of the register unchanged.
- R10: A bit write (bit_en) clears every bit selected by bit_mask and then sets those bits if bit_val is 1. Unselected bits keep their value.
- R11: With no reset, no load, no update and no bit write, the register holds its value.
- R12: When an update and a bit write arrive in the same cycle without a load, the update takes effect and the bit write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load the whole byte |
| load_val | input | 8 | Byte to load |
| upd_en | input | 1 | Flag update strobe |
| opc | input | 2 | Operation class: 0 add, 1 subtract, 2 test, 3 shift |
| wide | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| res | input | 16 | Result from the datapath |
| bit_en | input | 1 | Masked bit write strobe |
| bit_mask | input | 8 | Bits selected by the bit write |
| bit_val | input | 1 | Value written to the selected bits |
| ccr_q | output | 8 | Registered condition code byte |

## Verification
The assertions check the following on every cycle:
- the reset value;
- load priority;
- storage bits that stay put during an update;
- N from the result MSB at the chosen width;
- V cleared by the test class and the shift V relation, each with C held;
- bit writes that leave unselected bits alone;
- holding when idle.

Only the bench scenarios show the carry and overflow values for add and subtract. These include signed overflow at both widths, carry and borrow out of the top bit, and zero results. The scenarios also cover junk upper bytes in 8-bit mode, and the same-cycle orderings of load, update and bit write.

// File: rtl/ccr_flag_pkg.sv
package ccr_flag_pkg;

   localparam int CCR_W = 8;

   localparam int FB_C = 0;
   localparam int FB_V = 1;
   localparam int FB_Z = 2;
   localparam int FB_N = 3;
   localparam int FB_I = 4;
   localparam int FB_H = 5;
   localparam int FB_X = 6;
   localparam int FB_S = 7;

   typedef enum logic [1:0] {
      OPC_ADD   = 2'd0,
      OPC_SUB   = 2'd1,
      OPC_TEST  = 2'd2,
      OPC_SHIFT = 2'd3
   } opc_e;

   typedef struct packed {
      logic a;
      logic b;
      logic r;
      logic zero;
   } tap_t;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } nzvc_t;

endpackage

// File: rtl/ccr_msb_tap.sv
module ccr_msb_tap
   import ccr_flag_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] res,
   input  logic              wide,
   output tap_t              tap
);

   localparam int HI_W = DATA_W - 1;
   localparam int HI_N = NARROW_W - 1;

   logic zero_wide;
   logic zero_narrow;

   assign zero_wide   = (res == '0);
   assign zero_narrow = (res[HI_N:0] == '0);

   assign tap.a    = wide ? opa[HI_W] : opa[HI_N];
   assign tap.b    = wide ? opb[HI_W] : opb[HI_N];
   assign tap.r    = wide ? res[HI_W] : res[HI_N];
   assign tap.zero = wide ? zero_wide : zero_narrow;

endmodule

// File: rtl/ccr_nzvc_eval.sv
module ccr_nzvc_eval
   import ccr_flag_pkg::*;
(
   input  opc_e  opc,
   input  tap_t  tap,
   input  logic  c_now,
   output nzvc_t flg
);

   always_comb begin
      flg.n = tap.r;
      flg.z = tap.zero;
      flg.v = 1'b0;
      flg.c = c_now;
      unique case (opc)
         OPC_ADD: begin
            flg.c = (tap.a & tap.b) | (tap.b & ~tap.r) | (tap.a & ~tap.r);
            flg.v = (tap.a & tap.b & ~tap.r) | (~tap.a & ~tap.b & tap.r);
         end
         OPC_SUB: begin
            flg.c = (~tap.a & tap.b) | (tap.b & tap.r) | (~tap.a & tap.r);
            flg.v = (tap.a & ~tap.b & ~tap.r) | (~tap.a & tap.b & tap.r);
         end
         OPC_TEST: begin
            flg.v = 1'b0;
         end
         OPC_SHIFT: begin
            flg.v = tap.r ^ c_now;
         end
         default: begin
            flg.v = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/ccr_state_reg.sv
module ccr_state_reg
   import ccr_flag_pkg::*;
#(
   parameter logic [CCR_W-1:0] RST_VAL = 8'hD0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [CCR_W-1:0] load_val,
   input  logic             upd_en,
   input  nzvc_t            flg,
   input  logic             bit_en,
   input  logic [CCR_W-1:0] bit_mask,
   input  logic             bit_val,
   output logic [CCR_W-1:0] ccr_q
);

   logic [CCR_W-1:0] upd_val;
   logic [CCR_W-1:0] nxt;

   for (genvar i = 0; i < CCR_W; i++) begin : g_bit
      if (i == FB_N) begin : g_n
         assign upd_val[i] = flg.n;
      end else if (i == FB_Z) begin : g_z
         assign upd_val[i] = flg.z;
      end else if (i == FB_V) begin : g_v
         assign upd_val[i] = flg.v;
      end else if (i == FB_C) begin : g_c
         assign upd_val[i] = flg.c;
      end else begin : g_store
         assign upd_val[i] = ccr_q[i];
      end

      always_comb begin
         if (load_en) begin
            nxt[i] = load_val[i];
         end else if (upd_en) begin
            nxt[i] = upd_val[i];
         end else if (bit_en && bit_mask[i]) begin
            nxt[i] = bit_val;
         end else begin
            nxt[i] = ccr_q[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ccr_q <= RST_VAL;
      end else begin
         ccr_q <= nxt;
      end
   end

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
   import ccr_flag_pkg::*;
#(
   parameter int               DATA_W   = 16,
   parameter int               NARROW_W = 8,
   parameter logic [CCR_W-1:0] RST_VAL  = 8'hD0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic [CCR_W-1:0]  load_val,
   input  logic              upd_en,
   input  logic [1:0]        opc,
   input  logic              wide,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] res,
   input  logic              bit_en,
   input  logic [CCR_W-1:0]  bit_mask,
   input  logic              bit_val,
   output logic [CCR_W-1:0]  ccr_q
);

   if (NARROW_W < 2) begin : g_bad_narrow
      $error("NARROW_W must be at least 2");
   end
   if (NARROW_W > DATA_W) begin : g_bad_order
      $error("NARROW_W must not exceed DATA_W");
   end

   tap_t  tap;
   nzvc_t flg;
   opc_e  opc_t;

   assign opc_t = opc_e'(opc);

   ccr_msb_tap #(
      .DATA_W  (DATA_W),
      .NARROW_W(NARROW_W)
   ) u_tap (
      .opa (opa),
      .opb (opb),
      .res (res),
      .wide(wide),
      .tap (tap)
   );

   ccr_nzvc_eval u_eval (
      .opc  (opc_t),
      .tap  (tap),
      .c_now(ccr_q[FB_C]),
      .flg  (flg)
   );

   ccr_state_reg #(
      .RST_VAL(RST_VAL)
   ) u_reg (
      .clk     (clk),
      .rst     (rst),
      .load_en (load_en),
      .load_val(load_val),
      .upd_en  (upd_en),
      .flg     (flg),
      .bit_en  (bit_en),
      .bit_mask(bit_mask),
      .bit_val (bit_val),
      .ccr_q   (ccr_q)
   );

endmodule

// File: rtl/ccr_flag_chk.sv
module ccr_flag_chk
   import ccr_flag_pkg::*;
#(
   parameter int               DATA_W   = 16,
   parameter int               NARROW_W = 8,
   parameter logic [CCR_W-1:0] RST_VAL  = 8'hD0
) (
   input logic              clk,
   input logic              rst,
   input logic              load_en,
   input logic [CCR_W-1:0]  load_val,
   input logic              upd_en,
   input logic [1:0]        opc,
   input logic              wide,
   input logic [DATA_W-1:0] res,
   input logic              bit_en,
   input logic [CCR_W-1:0]  bit_mask,
   input logic              bit_val,
   input logic [CCR_W-1:0]  ccr_q
);

   logic upd_only;
   logic bit_only;
   logic idle;

   assign upd_only = upd_en && !load_en;
   assign bit_only = bit_en && !upd_en && !load_en;
   assign idle     = !load_en && !upd_en && !bit_en;

   // R1
   a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> ccr_q == RST_VAL);

   a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
      load_en |=> ccr_q == $past(load_val));

   a_r5_n_from_msb: assert property (@(posedge clk) disable iff (rst)
      upd_only |=> ccr_q[FB_N] ==
         $past(wide ? res[DATA_W-1] : res[NARROW_W-1]));

   a_r6_test_clears_v: assert property (@(posedge clk) disable iff (rst)
      (upd_only && opc == 2'd2) |=>
         (!ccr_q[FB_V] && ccr_q[FB_C] == $past(ccr_q[FB_C])));

   a_r7_shift_v: assert property (@(posedge clk) disable iff (rst)
      (upd_only && opc == 2'd3) |=>
         ((ccr_q[FB_V] == (ccr_q[FB_N] ^ ccr_q[FB_C])) &&
          ccr_q[FB_C] == $past(ccr_q[FB_C])));

   // R9 and R12: an update never disturbs the storage bits, even with a bit write
   a_r9_store_bits_kept: assert property (@(posedge clk) disable iff (rst)
      upd_only |=> ccr_q[7:4] == $past(ccr_q[7:4]));

   a_r10_bit_write: assert property (@(posedge clk) disable iff (rst)
      bit_only |=>
         (((ccr_q & ~$past(bit_mask)) == ($past(ccr_q) & ~$past(bit_mask))) &&
          ((ccr_q & $past(bit_mask)) == ($past(bit_val) ? $past(bit_mask) : 8'h00))));

   a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
      idle |=> $stable(ccr_q));

endmodule

bind ccr_flag_unit ccr_flag_chk #(
   .DATA_W  (DATA_W),
   .NARROW_W(NARROW_W),
   .RST_VAL (RST_VAL)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .load_en (load_en),
   .load_val(load_val),
   .upd_en  (upd_en),
   .opc     (opc),
   .wide    (wide),
   .res     (res),
   .bit_en  (bit_en),
   .bit_mask(bit_mask),
   .bit_val (bit_val),
   .ccr_q   (ccr_q)
);

// File: tb/sim_ccr_flag_unit.sv
`timescale 1ns/1ps
module sim_ccr_flag_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_en = 1'b0;
   logic [7:0]  load_val = '0;
   logic        upd_en = 1'b0;
   logic [1:0]  opc = '0;
   logic        wide = 1'b0;
   logic [15:0] opa = '0;
   logic [15:0] opb = '0;
   logic [15:0] res = '0;
   logic        bit_en = 1'b0;
   logic [7:0]  bit_mask = '0;
   logic        bit_val = 1'b0;
   logic [7:0]  ccr_q;

   ccr_flag_unit u0 (
      .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
      .upd_en(upd_en), .opc(opc), .wide(wide), .opa(opa), .opb(opb),
      .res(res), .bit_en(bit_en), .bit_mask(bit_mask), .bit_val(bit_val),
      .ccr_q(ccr_q)
   );

   always #10 clk = ~clk;

   typedef struct {
      int          due;
      logic [7:0]  exp;
      logic [31:0] tag;
   } item_t;

   item_t      sb[$];
   int         cyc = 0;
   int         n_chk = 0;
   int         n_fail = 0;
   logic [7:0] m = 8'hD0;
   bit         done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare each expected item in the cycle it falls due
   always @(negedge clk) begin
      if (sb.size() > 0 && sb[0].due <= cyc) begin
         item_t it;
         it = sb.pop_front();
         n_chk++;
         if (ccr_q !== it.exp) begin
            n_fail++;
            $display("FAIL %s: ccr_q=%02h expected %02h", it.tag, ccr_q, it.exp);
         end
      end
   end

   function automatic logic [7:0] model(
      input logic [7:0] cur, input logic ld, input logic [7:0] ldv,
      input logic up, input logic [1:0] oc, input logic w,
      input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
      input logic be, input logic [7:0] bm, input logic bv);
      logic [15:0] aw, bw, rw;
      logic [16:0] s;
      logic am, bmsb, rm, n, z, v, c;
      logic [7:0] o;
      aw = w ? a : {8'h00, a[7:0]};
      bw = w ? b : {8'h00, b[7:0]};
      rw = w ? r : {8'h00, r[7:0]};
      am   = w ? a[15] : a[7];
      bmsb = w ? b[15] : b[7];
      rm   = w ? r[15] : r[7];
      n = rm;
      z = (rw == 16'h0);
      c = cur[0];
      v = 1'b0;
      if (oc == 2'd0) begin
         s = {1'b0, aw} + {1'b0, bw};
         c = w ? s[16] : s[8];
         v = (am == bmsb) && (rm != am);
      end else if (oc == 2'd1) begin
         c = (aw < bw);
         v = (am != bmsb) && (rm != am);
      end else if (oc == 2'd3) begin
         v = n ^ cur[0];
      end
      if (ld) o = ldv;
      else if (up) o = {cur[7:4], n, z, v, c};
      else if (be) o = (cur & ~bm) | (bv ? bm : 8'h00);
      else o = cur;
      return o;
   endfunction

   task automatic drive(input logic [31:0] tag, input logic ld, input logic [7:0] ldv,
                        input logic up, input logic [1:0] oc, input logic w,
                        input logic [15:0] a, input logic [15:0] b, input logic [15:0] r,
                        input logic be, input logic [7:0] bm, input logic bv);
      item_t it;
      @(negedge clk);
      rst = 1'b0; load_en = ld; load_val = ldv; upd_en = up; opc = oc; wide = w;
      opa = a; opb = b; res = r; bit_en = be; bit_mask = bm; bit_val = bv;
      m = model(m, ld, ldv, up, oc, w, a, b, r, be, bm, bv);
      it.due = cyc + 1; it.exp = m; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic do_op(input logic [31:0] tag, input logic [1:0] oc, input logic w,
                        input logic [15:0] a, input logic [15:0] b);
      logic [15:0] r;
      if (oc == 2'd0) r = a + b;
      else if (oc == 2'd1) r = a - b;
      else r = a;
      drive(tag, 1'b0, 8'h00, 1'b1, oc, w, a, b, r, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic do_load(input logic [31:0] tag, input logic [7:0] v);
      drive(tag, 1'b1, v, 1'b0, 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 8'h00, 1'b0);
   endtask

   task automatic do_bits(input logic [31:0] tag, input logic [7:0] bm, input logic bv);
      drive(tag, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1, bm, bv);
   endtask

   task automatic do_idle(input logic [31:0] tag);
      drive(tag, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0, 1'b0, 8'hFF, 1'b1);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      item_t it;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      // R1: reset value visible after a reset edge
      it.due = cyc + 1; it.exp = 8'hD0; it.tag = "R1";
      sb.push_back(it);
      m = 8'hD0;
      do_idle("R11");
      do_idle("R11");
      // R3 add, narrow
      do_op("R3", 2'd0, 1'b0, 16'h007F, 16'h0001);   // V,N set
      do_op("R3", 2'd0, 1'b0, 16'h00FF, 16'h0001);   // C,Z set
      do_op("R3", 2'd0, 1'b0, 16'h0080, 16'h0080);   // C,V,Z
      // R3 add, wide
      do_op("R3", 2'd0, 1'b1, 16'hFFFF, 16'h0001);
      do_op("R3", 2'd0, 1'b1, 16'h7FFF, 16'h0001);
      // R8: junk upper byte ignored in narrow mode
      do_op("R8", 2'd0, 1'b0, 16'hAB7F, 16'hCD01);
      do_op("R8", 2'd0, 1'b1, 16'h00FF, 16'h0001);   // wide: no carry, not zero
      // R4 subtract
      do_op("R4", 2'd1, 1'b0, 16'h0000, 16'h0001);   // borrow, N
      do_op("R4", 2'd1, 1'b0, 16'h0080, 16'h0001);   // V
      do_op("R4", 2'd1, 1'b1, 16'h8000, 16'h0001);
      do_op("R4", 2'd1, 1'b1, 16'h1234, 16'h1234);   // Z
      // R6 test clears V, keeps C
      do_load("R2", 8'h03);
      do_op("R6", 2'd2, 1'b0, 16'h0000, 16'h0000);
      do_op("R5", 2'd2, 1'b1, 16'h8001, 16'h0000);
      // R7 shift with C=0 then C=1
      do_load("R2", 8'h00);
      do_op("R7", 2'd3, 1'b0, 16'h0080, 16'h0000);
      do_bits("R10", 8'h01, 1'b1);
      do_op("R7", 2'd3, 1'b0, 16'h0080, 16'h0000);
      do_op("R7", 2'd3, 1'b0, 16'hFF01, 16'h0000);
      // R9: storage bits kept across updates
      do_load("R2", 8'hF0);
      do_op("R9", 2'd0, 1'b0, 16'h00FF, 16'h00FF);
      // R10 bit writes, multi-bit masks
      do_bits("R10", 8'hA5, 1'b0);
      do_bits("R10", 8'h0C, 1'b1);
      // R2 load beats update and bit write
      drive("R2", 1'b1, 8'h5A, 1'b1, 2'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b1, 8'hFF, 1'b1);
      // R12 update beats bit write
      drive("R12", 1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 16'h0, 16'h0, 16'h0000, 1'b1, 8'hF0, 1'b0);
      do_idle("R11");
      do_idle("R11");
      // R1 reset again from a nonzero state
      @(negedge clk);
      rst = 1'b1; load_en = 1'b0; upd_en = 1'b0; bit_en = 1'b0;
      m = 8'hD0;
      it.due = cyc + 1; it.exp = 8'hD0; it.tag = "R1";
      sb.push_back(it);
      do_idle("R11");
      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule